// File: doc/BRIEF.md
# Interval Timer Count Channel

This block is a single channel of a programmable interval timer. A 16-bit down-counter is loaded and inspected over a byte-wide register interface. A control-word strobe either freezes a snapshot of the count or programs the channel's operating mode. Data writes load the count low byte first and then the high byte. Data reads return either the running count or the frozen snapshot, also low byte first. The counter advances one step on each cycle that the count-enable input is high. That input is meant to come from a divider that produces the nominal 1.19318 MHz timer rate.

In mode 0 the channel acts as a one-shot. The output rises at terminal count and the counter stops at zero. In modes 2 and 3 the counter reloads its programmed period at terminal count and keeps running, and the output is left unchanged. A status byte shows the channel output in a fixed bit position, so that system software can read the channel that drives the speaker. Control words with unsupported fields raise a flag and are otherwise ignored.

Top module: `pit_chan`

## Requirements
- R1: After reset the count, snapshot, period and read data are zero. The output, the unsupported flag and the status byte are low. The counter is stopped, the mode is 0, no snapshot is pending, and both byte pointers point at the low byte.
- R2: A control word acts only when its field [7:6] equals the channel number CHAN_ID (default 2). A word that addresses another channel changes nothing in this channel.
- R3: The unsupported flag is updated on every control-word write and holds its value until the next one. It is set when [7:6]=3, or when a word for this channel has an access field [5:4] of 1 or 2, a mode field [3:1] other than 0, 2 or 3, or bit [0] set. Such a word leaves the mode unchanged.
- R4: An access field of 0 copies the current count into the snapshot register. While a snapshot is already pending, a further latch command is ignored.
- R5: While a snapshot is pending, reads return its low byte and then its high byte. Reading the high byte releases the snapshot.
- R6: With no snapshot pending, reads alternate between the low byte and the high byte of the running count. Read data appears one cycle after the read strobe and then holds.
- R7: An accepted latch command points the read sequence back at the low byte.
- R8: A low-byte data write replaces count[7:0], stops counting and drives the output low.
- R9: A high-byte data write replaces count[15:8] and makes the full 16-bit value the reload period. Counting starts only if that value is nonzero.
- R10: While running, the count drops by one on each cycle with the count enable high, and holds on every other cycle.
- R11: In mode 0 (mode field 0), the count step from 1 to 0 drives the output high and stops the counter at zero. The output stays high until the next low-byte write.
- R12: In mode 2 or 3 (mode field 2 or 3), the step at count 1 reloads the period instead of reaching zero, and the output is unchanged.
- R13: When CHAN_ID equals SPKR_CHAN (both 2 by default), bit 5 of the status byte equals the channel output and every other bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one count step per high cycle |
| wr_ctrl | input | 1 | Control-word write strobe |
| wr_data | input | 1 | Count data write strobe |
| rd_data | input | 1 | Count data read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, registered |
| cnt_out | output | 1 | Channel output |
| unsup | output | 1 | Last control word was unsupported |
| port_status | output | 8 | Status byte carrying the speaker bit |

## Verification
Every result of this block is registered once, so each effect is due on the first clock edge after its strobe or count-enable cycle. The bench drives each stimulus on a falling edge, drops it on the next falling edge, and samples the outputs at that point, after exactly one rising edge. Count-enable bursts of n cycles are n rising edges long, and the bench works out the expected count from that number. Reads of the running count are issued only while count enable is low, so no count step can slip in between the two byte reads.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [2:0] MODE_ONESHOT = 3'd0;
    localparam logic [2:0] MODE_RATE    = 3'd2;
    localparam logic [2:0] MODE_SQUARE  = 3'd3;

    localparam logic [1:0] ACC_LATCH = 2'd0;
    localparam logic [1:0] ACC_WORD  = 2'd3;
    localparam logic [1:0] SEL_RDBK  = 2'd3;

    typedef enum logic {BYTE_LO = 1'b0, BYTE_HI = 1'b1} byte_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic             run;
        byte_sel_e        wptr;
        logic             out;
        logic [2:0]       mode;
    } cnt_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  snap;
        logic              held;
        byte_sel_e         rptr;
        logic [BYTE_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
    import pit_chan_pkg::*;
#(
    parameter int CHAN_ID = 2
) (
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic              latch_cmd,
    output logic              setup_cmd,
    output logic              bad_cmd,
    output logic [2:0]        mode_o
);
    logic [1:0] sel;
    logic [1:0] acc;
    logic       ours;
    logic       mode_ok;

    always_comb begin
        sel       = wdata[7:6];
        acc       = wdata[5:4];
        mode_o    = wdata[3:1];
        ours      = (sel == 2'(CHAN_ID));
        mode_ok   = (mode_o == MODE_ONESHOT) || (mode_o == MODE_RATE) ||
                    (mode_o == MODE_SQUARE);
        latch_cmd = wr_ctrl && ours && (acc == ACC_LATCH);
        setup_cmd = wr_ctrl && ours && (acc == ACC_WORD) && mode_ok && !wdata[0];
        bad_cmd   = wr_ctrl && ((sel == SEL_RDBK) ||
                    (ours && (acc != ACC_LATCH) &&
                     ((acc != ACC_WORD) || !mode_ok || wdata[0])));
    end

endmodule

// File: rtl/pit_down_cnt.sv
module pit_down_cnt
    import pit_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              setup_cmd,
    input  logic [2:0]        mode_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              out_o
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (setup_cmd) st_d.mode = mode_i;
        if (wr_data) begin
            if (st_q.wptr == BYTE_LO) begin
                st_d.count[BYTE_W-1:0] = wdata;
                st_d.run  = 1'b0;
                st_d.out  = 1'b0;
                st_d.wptr = BYTE_HI;
            end else begin
                st_d.count[CNT_W-1:BYTE_W] = wdata;
                st_d.period = {wdata, st_q.count[BYTE_W-1:0]};
                st_d.run    = ({wdata, st_q.count[BYTE_W-1:0]} != '0);
                st_d.wptr   = BYTE_LO;
            end
        end else if (st_q.run && tick_en) begin
            if (st_q.count <= CNT_W'(1)) begin
                if (st_q.mode == MODE_ONESHOT) begin
                    st_d.count = '0;
                    st_d.out   = 1'b1;
                    st_d.run   = 1'b0;
                end else begin
                    st_d.count = st_q.period;
                end
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{count: '0, period: '0, run: 1'b0, wptr: BYTE_LO,
                             out: 1'b0, mode: MODE_ONESHOT};
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign out_o   = st_q.out;

    // R8: a low-byte write quiets the output and halts the count
    a_r8_lo_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && st_q.wptr == BYTE_LO) |=> (!st_q.out && !st_q.run));
    // R11: once high, the output stays high until a data write
    a_r11_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out && !wr_data) |=> st_q.out);
    // R10: a stopped counter holds its value without a data write
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_data) |=> $stable(st_q.count));
    // R12: a running counter never sits at zero
    a_r12_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.count != '0));

endmodule

// File: rtl/pit_read_seq.sv
module pit_read_seq
    import pit_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_cmd,
    input  logic              rd_stb,
    input  logic [CNT_W-1:0]  count_i,
    output logic [BYTE_W-1:0] rdata_o
);
    rd_state_t rs_d, rs_q;
    logic [CNT_W-1:0] src;

    always_comb begin
        rs_d = rs_q;
        src  = rs_q.held ? rs_q.snap : count_i;
        if (latch_cmd && !rs_q.held) begin
            rs_d.held = 1'b1;
            rs_d.snap = count_i;
            rs_d.rptr = BYTE_LO;
        end else if (rd_stb) begin
            if (rs_q.rptr == BYTE_LO) begin
                rs_d.rdata = src[BYTE_W-1:0];
                rs_d.rptr  = BYTE_HI;
            end else begin
                rs_d.rdata = src[CNT_W-1:BYTE_W];
                rs_d.rptr  = BYTE_LO;
                rs_d.held  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{snap: '0, held: 1'b0, rptr: BYTE_LO, rdata: '0};
        else        rs_q <= rs_d;
    end

    assign rdata_o = rs_q.rdata;

    // R4: a pending snapshot is not overwritten by another latch command
    a_r4_latch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.held && latch_cmd && !rd_stb) |=> $stable(rs_q.snap));
    // R5: reading the high byte of a snapshot releases it
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.held && rd_stb && rs_q.rptr == BYTE_HI) |=> !rs_q.held);
    // R6: read data only moves on a read strobe
    a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rs_q.rdata));

endmodule

// File: rtl/pit_chan.sv
module pit_chan
    import pit_chan_pkg::*;
#(
    parameter int CHAN_ID   = 2,
    parameter int SPKR_CHAN = 2,
    parameter int SPKR_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              cnt_out,
    output logic              unsup,
    output logic [BYTE_W-1:0] port_status
);
    logic             latch_cmd, setup_cmd, bad_cmd;
    logic [2:0]       new_mode;
    logic [CNT_W-1:0] count;
    logic             unsup_d, unsup_q;

    pit_ctrl_dec #(.CHAN_ID(CHAN_ID)) u_dec (
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .latch_cmd (latch_cmd),
        .setup_cmd (setup_cmd),
        .bad_cmd   (bad_cmd),
        .mode_o    (new_mode)
    );

    pit_down_cnt u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_data   (wr_data),
        .wdata     (wdata),
        .setup_cmd (setup_cmd),
        .mode_i    (new_mode),
        .count_o   (count),
        .out_o     (cnt_out)
    );

    pit_read_seq u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_cmd (latch_cmd),
        .rd_stb    (rd_data),
        .count_i   (count),
        .rdata_o   (rdata)
    );

    always_comb begin
        unsup_d = unsup_q;
        if (wr_ctrl) unsup_d = bad_cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unsup_q <= 1'b0;
        else        unsup_q <= unsup_d;
    end

    assign unsup = unsup_q;

    generate
        if (CHAN_ID == SPKR_CHAN) begin : g_spkr
            assign port_status = BYTE_W'(cnt_out) << SPKR_BIT;
        end else begin : g_nospkr
            assign port_status = '0;
        end
    endgenerate

    // R3: the flag only rises after a control-word write
    a_r3_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unsup_q) |-> $past(wr_ctrl));
    // R3: without a control-word write the flag holds
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(unsup_q));

endmodule

// File: tb/pit_chan_tb_top.sv
module pit_chan_tb_top;
    localparam logic [2:0] OP_CTRL = 3'd0;
    localparam logic [2:0] OP_WR   = 3'd1;
    localparam logic [2:0] OP_RD   = 3'd2;
    localparam logic [2:0] OP_TICK = 3'd3;
    localparam logic [2:0] OP_OUT  = 3'd4;
    localparam int NV = 61;

    // {op, argument, expected, requirement}
    localparam logic [22:0] VEC [0:NV-1] = '{
        {OP_CTRL, 8'hB0, 8'h00, 4'd2},   // R2 mode 0 setup accepted
        {OP_WR,   8'h05, 8'h00, 4'd9},
        {OP_WR,   8'h00, 8'h00, 4'd9},
        {OP_OUT,  8'h00, 8'h00, 4'd9},   // R9
        {OP_TICK, 8'h04, 8'h00, 4'd10},  // count 5 -> 1
        {OP_CTRL, 8'h80, 8'h00, 4'd4},   // R4 snapshot of 1
        {OP_RD,   8'h00, 8'h01, 4'd5},   // R5
        {OP_RD,   8'h00, 8'h00, 4'd5},
        {OP_OUT,  8'h00, 8'h00, 4'd11},  // R11 not yet
        {OP_TICK, 8'h01, 8'h00, 4'd11},
        {OP_OUT,  8'h00, 8'h01, 4'd11},  // R11 R13 high at terminal
        {OP_TICK, 8'h03, 8'h00, 4'd11},
        {OP_RD,   8'h00, 8'h00, 4'd11},  // R11 stopped at zero
        {OP_RD,   8'h00, 8'h00, 4'd11},
        {OP_OUT,  8'h00, 8'h01, 4'd11},
        {OP_WR,   8'h10, 8'h00, 4'd8},
        {OP_OUT,  8'h00, 8'h00, 4'd8},   // R8 output forced low
        {OP_TICK, 8'h05, 8'h00, 4'd8},
        {OP_RD,   8'h00, 8'h10, 4'd8},   // R8 counting stopped
        {OP_RD,   8'h00, 8'h00, 4'd8},
        {OP_WR,   8'h01, 8'h00, 4'd9},   // 0x0110 running
        {OP_TICK, 8'h10, 8'h00, 4'd10},
        {OP_RD,   8'h00, 8'h00, 4'd10},  // R10 0x0100
        {OP_RD,   8'h00, 8'h01, 4'd10},
        {OP_CTRL, 8'hB4, 8'h00, 4'd12},  // mode 2
        {OP_WR,   8'h03, 8'h00, 4'd12},
        {OP_WR,   8'h00, 8'h00, 4'd12},
        {OP_TICK, 8'h03, 8'h00, 4'd12},  // 3,2,1 -> reload 3
        {OP_RD,   8'h00, 8'h03, 4'd12},  // R12
        {OP_RD,   8'h00, 8'h00, 4'd12},
        {OP_OUT,  8'h00, 8'h00, 4'd12},
        {OP_TICK, 8'h01, 8'h00, 4'd12},
        {OP_RD,   8'h00, 8'h02, 4'd12},
        {OP_RD,   8'h00, 8'h00, 4'd12},
        {OP_CTRL, 8'hB6, 8'h00, 4'd12},  // mode 3
        {OP_WR,   8'h34, 8'h00, 4'd9},
        {OP_WR,   8'h12, 8'h00, 4'd9},
        {OP_RD,   8'h00, 8'h34, 4'd6},   // R6 live low, pointer to high
        {OP_CTRL, 8'h80, 8'h00, 4'd7},   // R7 snapshot 0x1234
        {OP_TICK, 8'h01, 8'h00, 4'd10},  // live 0x1233
        {OP_CTRL, 8'h80, 8'h00, 4'd4},   // R4 ignored
        {OP_RD,   8'h00, 8'h34, 4'd7},   // R7 pointer reset
        {OP_RD,   8'h00, 8'h12, 4'd5},   // R5 release
        {OP_RD,   8'h00, 8'h33, 4'd6},   // R6 live again
        {OP_RD,   8'h00, 8'h12, 4'd6},
        {OP_CTRL, 8'h00, 8'h00, 4'd2},   // R2 latch for channel 0
        {OP_TICK, 8'h01, 8'h00, 4'd2},
        {OP_RD,   8'h00, 8'h32, 4'd2},   // R2 no snapshot taken
        {OP_RD,   8'h00, 8'h12, 4'd2},
        {OP_CTRL, 8'hC0, 8'h01, 4'd3},   // R3 read-back
        {OP_CTRL, 8'h90, 8'h01, 4'd3},   // R3 low-only access
        {OP_CTRL, 8'hB1, 8'h01, 4'd3},   // R3 bcd
        {OP_CTRL, 8'hB0, 8'h00, 4'd3},   // R3 clears, mode 0
        {OP_CTRL, 8'hBA, 8'h01, 4'd3},   // R3 mode 5 refused
        {OP_WR,   8'h02, 8'h00, 4'd3},
        {OP_WR,   8'h00, 8'h00, 4'd3},
        {OP_TICK, 8'h02, 8'h00, 4'd3},
        {OP_OUT,  8'h00, 8'h01, 4'd3},   // R3 mode stayed 0
        {OP_WR,   8'h00, 8'h00, 4'd9},
        {OP_WR,   8'h00, 8'h00, 4'd9},   // zero period
        {OP_TICK, 8'h03, 8'h00, 4'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, wr_ctrl = 1'b0, wr_data = 1'b0, rd_data = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, port_status;
    logic       cnt_out, unsup;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pit_chan dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .rd_data(rd_data), .wdata(wdata), .rdata(rdata),
        .cnt_out(cnt_out), .unsup(unsup), .port_status(port_status)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        wdata   = d;
        wr_ctrl = (op == OP_CTRL);
        wr_data = (op == OP_WR);
        rd_data = (op == OP_RD);
        @(negedge clk);
        wr_ctrl = 1'b0; wr_data = 1'b0; rd_data = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, rdata, 8'h00);
        check(1, {7'b0, cnt_out}, 8'h00);
        check(1, {7'b0, unsup}, 8'h00);
        check(1, port_status, 8'h00);
        strobe(OP_RD, 8'h00); check(1, rdata, 8'h00);
        strobe(OP_RD, 8'h00); check(1, rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [7:0] arg, exp;
            int         req;
            op  = VEC[i][22:20];
            arg = VEC[i][19:12];
            exp = VEC[i][11:4];
            req = int'(VEC[i][3:0]);
            case (op)
                OP_CTRL: begin strobe(op, arg); check(req, {7'b0, unsup}, exp); end
                OP_WR:   strobe(op, arg);
                OP_RD:   begin strobe(op, arg); check(req, rdata, exp); end
                OP_TICK: ticks(int'(arg));
                default: begin
                    check(req, {7'b0, cnt_out}, exp);
                    check(13, port_status, exp << 5);   // R13
                end
            endcase
        end
        // R9 a zero period never starts, so the mode 0 output stays low
        check(9, {7'b0, cnt_out}, 8'h00);
        strobe(OP_RD, 8'h00); check(9, rdata, 8'h00);

        // R1 reset while the output is high clears it
        strobe(OP_WR, 8'h01); strobe(OP_WR, 8'h00); ticks(1);
        check(11, {7'b0, cnt_out}, 8'h01);
        strobe(OP_CTRL, 8'hC0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(1, {7'b0, cnt_out}, 8'h00);
        check(1, {7'b0, unsup}, 8'h00);
        check(1, port_status, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule